// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer whose write side and read side run on separate clocks. Words enter on the write clock when the write enable is high. They leave on the read clock when the read enable is high, and the two sides may be active in the same cycle. Each side learns the other side's position from a Gray-coded pointer passed through a two-flop synchronizer. The block reports empty, full and half-full status. It also reports almost-empty and almost-full, and the thresholds for these two flags are held in an offset register.

The offset register takes one of eight preset values at master reset. After that it can be rewritten through the data bus, a parallel load, or one bit per clock through a serial input. Several choices are captured while master reset is low: standard or fall-through read timing, synchronous or unsynchronised almost-flags, and the preset index. A partial reset empties the buffer but keeps the offsets and these mode choices. A rewind input lets the stored data be read again from the first location. An output enable forces the data output to zero.

Top module: `pfifo_top`

## Requirements
- R1: Words are read out in the order they were written. A write and a read in the same cycle both take effect.
- R2: In standard mode, `emptyOrRdy` is the empty flag and `fullOrRdy` is the full flag. Full is high when DEPTH words are held. Empty clears on the second read-clock edge after the write edge.
- R3: `halfFull` is high exactly when the write side counts more than DEPTH/2 words.
- R4: `almostEmpty` is high when the occupancy is no more than the almost-empty offset. `almostFull` is high when the occupancy is at least DEPTH minus the almost-full offset.
- R5: Master reset loads both offsets with a preset chosen by index {loadSel, presetSel}. The preset is 2^(index+3)-1, capped at DEPTH-1, so with DEPTH 64 the values are 7, 15, 31, 63, ...
- R6: A write with `loadSel` high does not enter the FIFO. It loads the low address bits of `dataIn` into the almost-empty offset, and the next such write loads the almost-full offset, alternating.
- R7: Each cycle with `serEn` high and `loadSel` low shifts `serIn` into the offsets. Over 2·log2(DEPTH) cycles the bits go LSB first, almost-empty offset first, then almost-full.
- R8: With `fwftSel` high at master reset, the first word appears on `dataOut` with no read enable, and `emptyOrRdy` means output-ready. A read enable moves the next word in. `fullOrRdy` means input-ready, which is the inverse of full.
- R9: With `flagAsync` high at master reset, the almost-flags compare the other side's pointer without synchronization, so `almostEmpty` reflects a write in the same cycle.
- R10: Master reset empties the buffer and reloads presets and modes. Partial reset empties the buffer but keeps the offsets and modes.
- R11: A `rewind` pulse returns the read pointer to the first stored word. The next read returns that word.
- R12: A write while full and a read while empty are ignored. Stored data and the pointers stay unchanged.
- R13: With `outEn` low, `dataOut` is zero. With `outEn` high, it shows the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| wrEn | input | 1 | Write enable |
| dataIn | input | WIDTH | Write data, also used for parallel offset load |
| loadSel | input | 1 | Offset load select; high bit of preset index at master reset |
| serEn | input | 1 | Serial offset shift enable |
| serIn | input | 1 | Serial offset data |
| rdClk | input | 1 | Read clock |
| rdEn | input | 1 | Read enable |
| rewind | input | 1 | Return read pointer to first word |
| outEn | input | 1 | Output enable (low gives zero) |
| dataOut | output | WIDTH | Read data |
| mrstN | input | 1 | Master reset, active low, synchronous |
| prstN | input | 1 | Partial reset, active low, synchronous |
| fwftSel | input | 1 | Fall-through timing select, captured at master reset |
| flagAsync | input | 1 | Unsynchronised almost-flag select, captured at master reset |
| presetSel | input | 2 | Low bits of preset index, captured at master reset |
| emptyOrRdy | output | 1 | Empty (standard) or output-ready (fall-through) |
| fullOrRdy | output | 1 | Full (standard) or input-ready (fall-through) |
| halfFull | output | 1 | More than half full |
| almostEmpty | output | 1 | Almost-empty flag |
| almostFull | output | 1 | Almost-full flag |

## Verification
The properties assume four things about the inputs:
- A rewind is only issued before the write pointer has wrapped, so the write side never counts more than DEPTH words.
- Resets are held for at least two edges of each clock.
- `dataIn` is at least as wide as the address.
- The mode inputs are steady while master reset is low.

The bench keeps within these limits. It drives every input at the falling clock edge and clocks both sides from one source. Before each rewind it writes fewer than DEPTH words. It also starts every test that fills the buffer from a fresh reset.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;
  // strobes handed from control to datapath
  typedef struct packed {
    logic wrStb;   // write-clock domain: store dataIn
    logic rdStb;   // read-clock domain: load output register
    logic clrOut;  // read-clock domain: clear output register
  } pfifoStb_t;
endpackage

// File: rtl/pfifo_sync.sv
module pfifo_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/pfifo_dpath.sv
module pfifo_dpath
  import pfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 9,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  pfifoStb_t        stb,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             outEn,
  output logic [WIDTH-1:0] dataOut
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] outReg;

  always_ff @(posedge wrClk) begin
    if (stb.wrStb) mem[wrAddr] <= dataIn;
  end

  always_ff @(posedge rdClk) begin
    if (stb.clrOut)     outReg <= '0;
    else if (stb.rdStb) outReg <= mem[rdAddr];
  end

  assign dataOut = outEn ? outReg : '0;
endmodule

// File: rtl/pfifo_ctrl.sv
module pfifo_ctrl
  import pfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          mrstN,
  input  logic          prstN,
  input  logic          wrEn,
  input  logic          loadSel,
  input  logic          serEn,
  input  logic          serIn,
  input  logic [AW-1:0] parData,
  input  logic          rdEn,
  input  logic          rewind,
  input  logic          fwftSel,
  input  logic          flagAsync,
  input  logic [1:0]    presetSel,
  output pfifoStb_t     stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          emptyOrRdy,
  output logic          fullOrRdy,
  output logic          halfFull,
  output logic          almostEmpty,
  output logic          almostFull
);
  localparam int PW = AW + 1;

  function automatic logic [AW-1:0] presetOf(input logic [2:0] idx);
    if (int'(idx) + 3 >= AW) return '1;
    else return AW'((1 << (int'(idx) + 3)) - 1);
  endfunction

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] toBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic rstAny;
  assign rstAny = !mrstN || !prstN;

  // configuration, write-clock domain; quasi-static for the read side
  logic fwftMode, asyncMode, parSel;
  logic [AW-1:0] aeOff, afOff;

  always_ff @(posedge wrClk) begin
    if (!mrstN) begin
      fwftMode  <= fwftSel;
      asyncMode <= flagAsync;
      aeOff     <= presetOf({loadSel, presetSel});
      afOff     <= presetOf({loadSel, presetSel});
      parSel    <= 1'b0;
    end else if (!prstN) begin
      parSel <= 1'b0;
    end else if (loadSel && wrEn) begin
      if (!parSel) aeOff <= parData;
      else         afOff <= parData;
      parSel <= !parSel;
    end else if (serEn && !loadSel) begin
      {afOff, aeOff} <= {serIn, afOff, aeOff[AW-1:1]};
    end
  end

  // pointers and synchronizers
  logic [PW-1:0] wrPtr, wrGray, rdPtr, rdGray;
  logic [PW-1:0] rdGraySyncW, wrGraySyncR, rdPtrW, wrPtrR;
  logic [PW-1:0] wordsW, wordsR;
  logic full, wrFire, rdFire, outValid;

  pfifo_sync #(.W(PW)) u_rdToWr (
    .clk(wrClk), .rst(rstAny), .din(rdGray), .dout(rdGraySyncW));
  pfifo_sync #(.W(PW)) u_wrToRd (
    .clk(rdClk), .rst(rstAny), .din(wrGray), .dout(wrGraySyncR));

  assign rdPtrW = toBin(rdGraySyncW);
  assign wrPtrR = toBin(wrGraySyncR);
  assign wordsW = wrPtr - rdPtrW;
  assign wordsR = wrPtrR - rdPtr;
  assign full   = (wordsW == PW'(DEPTH));
  assign wrFire = wrEn && !loadSel && !full;

  always_ff @(posedge wrClk) begin
    if (rstAny) begin
      wrPtr  <= '0;
      wrGray <= '0;
    end else if (wrFire) begin
      wrPtr  <= wrPtr + 1'b1;
      wrGray <= toGray(wrPtr + 1'b1);
    end
  end

  always_comb begin
    if (rewind)        rdFire = 1'b0;
    else if (fwftMode) rdFire = (wordsR != '0) && (!outValid || rdEn);
    else               rdFire = rdEn && (wordsR != '0);
  end

  always_ff @(posedge rdClk) begin
    if (rstAny || rewind) begin
      rdPtr    <= '0;
      rdGray   <= '0;
      outValid <= 1'b0;
    end else begin
      if (rdFire) begin
        rdPtr  <= rdPtr + 1'b1;
        rdGray <= toGray(rdPtr + 1'b1);
      end
      if (fwftMode) begin
        if (rdFire)    outValid <= 1'b1;
        else if (rdEn) outValid <= 1'b0;
      end
    end
  end

  // flags
  logic [PW-1:0] aeWords, afWords;
  assign aeWords = (asyncMode ? (wrPtr - rdPtr) : wordsR) + PW'(outValid);
  assign afWords = asyncMode ? (wrPtr - rdPtr) : wordsW;

  assign emptyOrRdy  = fwftMode ? outValid : (wordsR == '0);
  assign fullOrRdy   = fwftMode ? !full : full;
  assign halfFull    = wordsW > PW'(DEPTH / 2);
  assign almostEmpty = aeWords <= {1'b0, aeOff};
  assign almostFull  = afWords >= (PW'(DEPTH) - {1'b0, afOff});

  assign stb.wrStb  = wrFire;
  assign stb.rdStb  = rdFire;
  assign stb.clrOut = rstAny;
  assign wrAddr     = wrPtr[AW-1:0];
  assign rdAddr     = rdPtr[AW-1:0];

  // write side never counts past DEPTH (R12)
  a_r12_no_overflow: assert property (@(posedge wrClk) disable iff (rstAny)
    wordsW <= PW'(DEPTH));

  // write attempt while full leaves the write pointer alone (R12)
  a_r12_full_hold: assert property (@(posedge wrClk) disable iff (rstAny)
    full && !loadSel |=> $stable(wrPtr));

  // read attempt while empty leaves the read pointer alone (R12)
  a_r12_empty_hold: assert property (@(posedge rdClk) disable iff (rstAny)
    !fwftMode && (wordsR == '0) && !rewind |=> $stable(rdPtr));

  // rewind returns to the first location (R11)
  a_r11_rewind: assert property (@(posedge rdClk) disable iff (rstAny)
    rewind |=> (rdPtr == '0));

  // fall-through word stays presented until consumed (R8)
  a_r8_hold: assert property (@(posedge rdClk) disable iff (rstAny)
    fwftMode && outValid && !rdEn && !rewind |=> outValid);
endmodule

// File: rtl/pfifo_top.sv
module pfifo_top
  import pfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 9
) (
  input  logic             wrClk,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             loadSel,
  input  logic             serEn,
  input  logic             serIn,
  input  logic             rdClk,
  input  logic             rdEn,
  input  logic             rewind,
  input  logic             outEn,
  output logic [WIDTH-1:0] dataOut,
  input  logic             mrstN,
  input  logic             prstN,
  input  logic             fwftSel,
  input  logic             flagAsync,
  input  logic [1:0]       presetSel,
  output logic             emptyOrRdy,
  output logic             fullOrRdy,
  output logic             halfFull,
  output logic             almostEmpty,
  output logic             almostFull
);
  localparam int AW = $clog2(DEPTH);

  pfifoStb_t     stb;
  logic [AW-1:0] wrAddr, rdAddr;

  pfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .prstN(prstN),
    .wrEn(wrEn), .loadSel(loadSel), .serEn(serEn), .serIn(serIn),
    .parData(dataIn[AW-1:0]), .rdEn(rdEn), .rewind(rewind),
    .fwftSel(fwftSel), .flagAsync(flagAsync), .presetSel(presetSel),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .emptyOrRdy(emptyOrRdy), .fullOrRdy(fullOrRdy), .halfFull(halfFull),
    .almostEmpty(almostEmpty), .almostFull(almostFull));

  pfifo_dpath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dpath (
    .wrClk(wrClk), .rdClk(rdClk), .stb(stb), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .dataIn(dataIn), .outEn(outEn), .dataOut(dataOut));
endmodule

// File: tb/pfifo_top_tb.sv
`timescale 1ns/1ps
module pfifo_top_tb;
  localparam int DEPTH = 64;
  localparam int WIDTH = 9;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_I = 2'd2, OP_B = 2'd3;
  // {op, write data, expected read data}
  localparam logic [19:0] VEC [12] = '{
    {OP_W, 9'h011, 9'h000}, {OP_W, 9'h1A2, 9'h000}, {OP_W, 9'h0F3, 9'h000},
    {OP_I, 9'h000, 9'h000}, {OP_I, 9'h000, 9'h000}, {OP_R, 9'h000, 9'h011},
    {OP_B, 9'h155, 9'h1A2}, {OP_R, 9'h000, 9'h0F3}, {OP_I, 9'h000, 9'h000},
    {OP_I, 9'h000, 9'h000}, {OP_R, 9'h000, 9'h155}, {OP_I, 9'h000, 9'h000}};

  logic clk = 1'b0;
  logic wrEn = 0, loadSel = 0, serEn = 0, serIn = 0, rdEn = 0, rewind = 0;
  logic outEn = 1, mrstN = 0, prstN = 1, fwftSel = 0, flagAsync = 0;
  logic [1:0] presetSel = 0;
  logic [WIDTH-1:0] dataIn = '0;
  logic [WIDTH-1:0] dataOut;
  logic emptyOrRdy, fullOrRdy, halfFull, almostEmpty, almostFull;
  int nChecks = 0, nFail = 0;

  always #4 clk = ~clk;

  pfifo_top #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
    .wrClk(clk), .wrEn(wrEn), .dataIn(dataIn), .loadSel(loadSel),
    .serEn(serEn), .serIn(serIn), .rdClk(clk), .rdEn(rdEn), .rewind(rewind),
    .outEn(outEn), .dataOut(dataOut), .mrstN(mrstN), .prstN(prstN),
    .fwftSel(fwftSel), .flagAsync(flagAsync), .presetSel(presetSel),
    .emptyOrRdy(emptyOrRdy), .fullOrRdy(fullOrRdy), .halfFull(halfFull),
    .almostEmpty(almostEmpty), .almostFull(almostFull));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [WIDTH-1:0] d);
    wrEn = 1; dataIn = d; tick(1); wrEn = 0;
  endtask

  task automatic doRead();
    rdEn = 1; tick(1); rdEn = 0;
  endtask

  task automatic writeN(input int n, input int base);
    for (int k = 0; k < n; k++) doWrite(WIDTH'(base + k));
  endtask

  task automatic mreset(input logic fw, input logic fa, input logic [1:0] ps, input logic ls);
    mrstN = 0; fwftSel = fw; flagAsync = fa; presetSel = ps; loadSel = ls;
    wrEn = 0; rdEn = 0; serEn = 0; rewind = 0;
    tick(3);
    mrstN = 1; loadSel = 0;
    tick(1);
  endtask

  initial begin
    #(8 * 200000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [11:0] serBits;
    mreset(0, 0, 2'd0, 0);
    // R10 reset state, R2 flags
    check("R10 reset empty", emptyOrRdy, 1);
    check("R2 reset full", fullOrRdy, 0);
    check("R3 reset halfFull", halfFull, 0);
    check("R4 reset almostEmpty", almostEmpty, 1);
    check("R4 reset almostFull", almostFull, 0);
    check("R10 reset dataOut", dataOut, 0);

    // R1 table walk
    for (int v = 0; v < 12; v++) begin
      case (VEC[v][19:18])
        OP_W: doWrite(VEC[v][17:9]);
        OP_R: begin doRead(); check("R1 order", dataOut, VEC[v][8:0]); end
        OP_B: begin
          wrEn = 1; rdEn = 1; dataIn = VEC[v][17:9]; tick(1); wrEn = 0; rdEn = 0;
          check("R1 simultaneous", dataOut, VEC[v][8:0]);
        end
        default: tick(1);
      endcase
    end
    check("R2 drained empty", emptyOrRdy, 1);

    // R2 empty latency
    doWrite(9'h0AB);
    tick(1); check("R2 empty after one edge", emptyOrRdy, 1);
    tick(1); check("R2 empty clears second edge", emptyOrRdy, 0);
    doRead(); check("R1 read 0AB", dataOut, 9'h0AB);
    check("R2 empty after read", emptyOrRdy, 1);
    // R12 read while empty
    doRead(); tick(2);
    check("R12 empty read ignored", dataOut, 9'h0AB);
    doWrite(9'h0CD); tick(3); doRead();
    check("R12 pointer intact", dataOut, 9'h0CD);

    // fill test, offsets 7/7
    mreset(0, 0, 2'd0, 0);
    for (int i = 0; i < DEPTH; i++) begin
      doWrite(WIDTH'(i));
      if (i + 1 == 7)  begin tick(3); check("R4 ae at 7", almostEmpty, 1); end
      if (i + 1 == 8)  begin
        check("R9 sync ae lags", almostEmpty, 1);
        tick(3); check("R4 ae at 8", almostEmpty, 0);
      end
      if (i + 1 == 32) check("R3 hf at 32", halfFull, 0);
      if (i + 1 == 33) check("R3 hf at 33", halfFull, 1);
      if (i + 1 == 56) check("R4 af at 56", almostFull, 0);
      if (i + 1 == 57) check("R4 af at 57", almostFull, 1);
      if (i + 1 == 63) check("R2 full at 63", fullOrRdy, 0);
      if (i + 1 == 64) check("R2 full at 64", fullOrRdy, 1);
    end
    doWrite(9'h1FF); tick(3);
    for (int i = 0; i < DEPTH; i++) begin
      doRead(); check("R12 data after full write", dataOut, 32'(i));
    end
    tick(3);
    check("R12 full write dropped", emptyOrRdy, 1);

    // R11 rewind
    mreset(0, 0, 2'd0, 0);
    writeN(3, 9'h021); tick(3);
    doRead(); check("R11 first", dataOut, 9'h021);
    doRead(); check("R11 second", dataOut, 9'h022);
    rewind = 1; tick(1); rewind = 0;
    doRead(); check("R11 reread first", dataOut, 9'h021);
    doRead(); check("R11 reread second", dataOut, 9'h022);

    // R6 parallel load, R10 partial reset
    mreset(0, 0, 2'd0, 0);
    loadSel = 1; doWrite(9'd2); doWrite(9'd3); loadSel = 0;
    tick(3); check("R6 load not stored", emptyOrRdy, 1);
    doWrite(9'h077); tick(3); check("R10 word present", emptyOrRdy, 0);
    prstN = 0; tick(2); prstN = 1; tick(3);
    check("R10 partial reset empties", emptyOrRdy, 1);
    writeN(2, 0); tick(3); check("R6 ae at 2 kept", almostEmpty, 1);
    doWrite(0); tick(3); check("R10 ae at 3 kept", almostEmpty, 0);
    writeN(57, 0); check("R6 af at 60", almostFull, 0);
    doWrite(0); check("R6 af at 61", almostFull, 1);

    // R5 presets
    mreset(0, 0, 2'd1, 0);
    writeN(15, 0); tick(3); check("R5 preset1 ae at 15", almostEmpty, 1);
    doWrite(0); tick(3); check("R5 preset1 ae at 16", almostEmpty, 0);
    mreset(0, 0, 2'd3, 1);
    check("R5 preset7 af at 0", almostFull, 0);
    doWrite(0); tick(3);
    check("R5 preset7 af at 1", almostFull, 1);
    check("R5 preset7 ae at 1", almostEmpty, 1);

    // R7 serial load: ae=4, af=5
    mreset(0, 0, 2'd0, 0);
    serBits = {6'd5, 6'd4};
    serEn = 1;
    for (int b = 0; b < 12; b++) begin serIn = serBits[b]; tick(1); end
    serEn = 0;
    writeN(4, 0); tick(3); check("R7 ae at 4", almostEmpty, 1);
    doWrite(0); tick(3); check("R7 ae at 5", almostEmpty, 0);
    writeN(53, 0); check("R7 af at 58", almostFull, 0);
    doWrite(0); check("R7 af at 59", almostFull, 1);

    // R9 unsynchronised almost flags
    mreset(0, 1, 2'd0, 0);
    writeN(7, 0); check("R9 async ae at 7", almostEmpty, 1);
    doWrite(0); check("R9 async ae at 8 same cycle", almostEmpty, 0);

    // R8 fall-through
    mreset(1, 0, 2'd0, 0);
    check("R8 not ready at reset", emptyOrRdy, 0);
    check("R8 input ready at reset", fullOrRdy, 1);
    doWrite(9'h0E1); tick(3);
    check("R8 ready without read", emptyOrRdy, 1);
    check("R8 first word falls through", dataOut, 9'h0E1);
    doWrite(9'h0E2); doWrite(9'h0E3); tick(4);
    check("R8 word held", dataOut, 9'h0E1);
    doRead(); check("R8 next word", dataOut, 9'h0E2);
    doRead(); check("R8 third word", dataOut, 9'h0E3);
    doRead(); check("R8 not ready when drained", emptyOrRdy, 0);

    // R13 output enable
    outEn = 0; tick(1); check("R13 disabled zero", dataOut, 0);
    outEn = 1; tick(1); check("R13 enabled value", dataOut, 9'h0E3);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule